// File: doc/BRIEF.md
# Alternating-Chroma to 4:4:4 Pixel Converter

This block turns a valid-qualified pixel stream that carries a full-rate 10-bit luma sample and one 10-bit shared chroma sample per pixel, where the shared sample swaps between Cb and Cr on successive pixels, into a stream in which every pixel carries Y, Cb and Cr. Each chroma value is rebuilt by plain repetition. A Cb sample and the Cr sample that follows it form a pair, and both pixels of that pair get the same two values. Line-start and line-end markers travel with the pixel they belong to.

A second, independent path runs the other way. It takes a 4:4:4 stream and packs it back into the 24-bit alternating word. It keeps the luma of every pixel and keeps Cb on even pixels and Cr on odd pixels. Both paths count chroma phase from the line start, so a line that starts early or a line of odd length never leaves the pairing out of step.

Top module: `yc_alt_convert`

## Requirements
- R1: In the packed word, luma occupies bits 9:0, the shared chroma sample occupies bits 19:10 and bits 23:20 are padding. Padding on the unpack input has no effect on any output.
- R2: On the unpack path, the pixel flagged as line start has phase 0 and carries Cb. Later valid pixels of the line alternate Cr, Cb, Cr and so on.
- R3: Each unpacked output pixel of a pair carries the Cb of the pair's phase-0 pixel and the Cr of its phase-1 pixel, on both pixels of the pair.
- R4: When a line ends on a phase-0 pixel, that last pixel is output with Cr equal to its own Cb.
- R5: Unpacked pixels leave in input order, at most one per cycle, with their own line-start and line-end flags. A pixel's output is registered at the edge that accepts the next input pixel. A pixel flagged line end is registered one edge after it is accepted.
- R6: The luma of every unpacked output pixel equals the luma of the matching input pixel.
- R7: The pack path registers its word one cycle after the input, as {4'b0000, chroma, Y}. Its valid, line-start and line-end outputs are the inputs delayed by one cycle.
- R8: The pack path restarts at phase 0 on every line start. It emits Cb on phase-0 pixels and Cr on phase-1 pixels.
- R9: While reset is high and right after it, both output valid signals are low.
- R10: Cycles with valid low produce no output and do not advance the chroma phase on either path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Packed input pixel present |
| in_sol | input | 1 | Packed input pixel is first of line |
| in_eol | input | 1 | Packed input pixel is last of line |
| in_word | input | 24 | Packed pixel {pad, chroma, Y} |
| o_valid | output | 1 | 4:4:4 output pixel present |
| o_sol | output | 1 | 4:4:4 output pixel is first of line |
| o_eol | output | 1 | 4:4:4 output pixel is last of line |
| o_y | output | 10 | Output luma |
| o_cb | output | 10 | Output blue-difference chroma |
| o_cr | output | 10 | Output red-difference chroma |
| p_valid | input | 1 | 4:4:4 pack input pixel present |
| p_sol | input | 1 | Pack input pixel is first of line |
| p_eol | input | 1 | Pack input pixel is last of line |
| p_y | input | 10 | Pack input luma |
| p_cb | input | 10 | Pack input Cb |
| p_cr | input | 10 | Pack input Cr |
| pk_valid | output | 1 | Packed output word present |
| pk_sol | output | 1 | Packed output is first of line |
| pk_eol | output | 1 | Packed output is last of line |
| pk_word | output | 24 | Packed output {4'b0, chroma, Y} |

## Verification
The bench starts a new line in the same cycle that the previous line's last pixel is flushed. If the hold stage did not release that pixel first, a pixel would be dropped or would come out with the wrong flags. It runs lines of three pixels and one pixel, and a design without odd-line handling would send those last pixels out with the next line's chroma or with stale Cr. Idle gaps inside pairs would show up as a shifted Cb/Cr pairing if the phase advanced on invalid cycles. A line start on the pack side that lands on an odd phase would emit Cr first if the phase were not restarted. Nonzero padding on the input would leak into the outputs if the field slicing were off.

// File: rtl/yc_pkg.sv
package yc_pkg;
  localparam int COMP_W_DEF = 10;
  localparam int PAD_W_DEF  = 4;

  typedef enum logic {
    PH_CB = 1'b0,
    PH_CR = 1'b1
  } cph_e;
endpackage

// File: rtl/yc_phase_track.sv
module yc_phase_track
  import yc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic valid,
  input  logic sol,
  output cph_e cur_ph
);
  cph_e ph_q;

  assign cur_ph = sol ? PH_CB : ph_q;

  always_ff @(posedge clk) begin
    if (rst) ph_q <= PH_CB;
    else if (valid) ph_q <= (cur_ph == PH_CB) ? PH_CR : PH_CB;
  end

  AST_IDLE_HOLDS_PHASE: assert property (@(posedge clk) disable iff (rst)
    !valid |=> ph_q == $past(ph_q)); // R10
endmodule

// File: rtl/yc_unpack.sv
module yc_unpack
  import yc_pkg::*;
#(
  parameter int CW = COMP_W_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_sol,
  input  logic          in_eol,
  input  logic [CW-1:0] in_y,
  input  logic [CW-1:0] in_c,
  output logic          o_valid,
  output logic          o_sol,
  output logic          o_eol,
  output logic [CW-1:0] o_y,
  output logic [CW-1:0] o_cb,
  output logic [CW-1:0] o_cr
);
  cph_e in_ph;

  yc_phase_track u_ph (
    .clk   (clk),
    .rst   (rst),
    .valid (in_valid),
    .sol   (in_sol),
    .cur_ph(in_ph)
  );

  logic          h_v, h_sol, h_eol;
  cph_e          h_ph;
  logic [CW-1:0] h_y, h_c, h_cb;
  logic          emit, take_next;

  assign emit      = h_v && (in_valid || h_eol);
  assign take_next = (h_ph == PH_CB) && in_valid && !in_sol && !h_eol;

  always_ff @(posedge clk) begin
    if (rst) begin
      h_v     <= 1'b0;
      o_valid <= 1'b0;
      o_sol   <= 1'b0;
      o_eol   <= 1'b0;
    end else begin
      o_valid <= emit;
      o_sol   <= emit && h_sol;
      o_eol   <= emit && h_eol;
      if (in_valid) h_v <= 1'b1;
      else if (emit) h_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (emit) begin
      o_y  <= h_y;
      o_cb <= h_cb;
      o_cr <= take_next ? in_c : h_c;
    end
    if (in_valid) begin
      h_y   <= in_y;
      h_c   <= in_c;
      h_sol <= in_sol;
      h_eol <= in_eol;
      h_ph  <= in_ph;
      h_cb  <= (in_ph == PH_CR) ? h_c : in_c;
    end
  end

  AST_SINGLE_PIXEL_LINE: assert property (@(posedge clk) disable iff (rst)
    o_valid && o_sol && o_eol |-> o_cb == o_cr); // R4
  AST_EMIT_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    o_valid |-> $past(in_valid) || $past(h_v && h_eol)); // R5
  AST_NO_EMIT_FROM_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !$past(h_v) |-> !o_valid); // R5
endmodule

// File: rtl/yc_pack.sv
module yc_pack
  import yc_pkg::*;
#(
  parameter int CW = COMP_W_DEF,
  parameter int PW = PAD_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               p_valid,
  input  logic               p_sol,
  input  logic               p_eol,
  input  logic [CW-1:0]      p_y,
  input  logic [CW-1:0]      p_cb,
  input  logic [CW-1:0]      p_cr,
  output logic               pk_valid,
  output logic               pk_sol,
  output logic               pk_eol,
  output logic [2*CW+PW-1:0] pk_word
);
  localparam int WW = 2*CW + PW;

  cph_e ph;

  yc_phase_track u_ph (
    .clk   (clk),
    .rst   (rst),
    .valid (p_valid),
    .sol   (p_sol),
    .cur_ph(ph)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pk_valid <= 1'b0;
      pk_sol   <= 1'b0;
      pk_eol   <= 1'b0;
    end else begin
      pk_valid <= p_valid;
      pk_sol   <= p_valid && p_sol;
      pk_eol   <= p_valid && p_eol;
    end
  end

  always_ff @(posedge clk) begin
    if (p_valid) pk_word <= {{PW{1'b0}}, (ph == PH_CR) ? p_cr : p_cb, p_y};
  end

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    pk_valid |-> pk_word[WW-1:2*CW] == '0); // R7
  AST_LUMA_KEPT: assert property (@(posedge clk) disable iff (rst)
    pk_valid |-> pk_word[CW-1:0] == $past(p_y)); // R7
  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pk_valid == $past(p_valid)); // R7
  AST_SOL_IS_CB: assert property (@(posedge clk) disable iff (rst)
    pk_valid && pk_sol |-> pk_word[2*CW-1:CW] == $past(p_cb)); // R8
endmodule

// File: rtl/yc_alt_convert.sv
module yc_alt_convert
  import yc_pkg::*;
#(
  parameter int CW = COMP_W_DEF,
  parameter int PW = PAD_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               in_sol,
  input  logic               in_eol,
  input  logic [2*CW+PW-1:0] in_word,
  output logic               o_valid,
  output logic               o_sol,
  output logic               o_eol,
  output logic [CW-1:0]      o_y,
  output logic [CW-1:0]      o_cb,
  output logic [CW-1:0]      o_cr,
  input  logic               p_valid,
  input  logic               p_sol,
  input  logic               p_eol,
  input  logic [CW-1:0]      p_y,
  input  logic [CW-1:0]      p_cb,
  input  logic [CW-1:0]      p_cr,
  output logic               pk_valid,
  output logic               pk_sol,
  output logic               pk_eol,
  output logic [2*CW+PW-1:0] pk_word
);
  localparam int WW = 2*CW + PW;

  logic unused_pad_bits;
  assign unused_pad_bits = ^in_word[WW-1:2*CW];

  yc_unpack #(.CW(CW)) u_unpack (
    .clk     (clk),
    .rst     (rst),
    .in_valid(in_valid),
    .in_sol  (in_sol),
    .in_eol  (in_eol),
    .in_y    (in_word[CW-1:0]),
    .in_c    (in_word[2*CW-1:CW]),
    .o_valid (o_valid),
    .o_sol   (o_sol),
    .o_eol   (o_eol),
    .o_y     (o_y),
    .o_cb    (o_cb),
    .o_cr    (o_cr)
  );

  yc_pack #(.CW(CW), .PW(PW)) u_pack (
    .clk     (clk),
    .rst     (rst),
    .p_valid (p_valid),
    .p_sol   (p_sol),
    .p_eol   (p_eol),
    .p_y     (p_y),
    .p_cb    (p_cb),
    .p_cr    (p_cr),
    .pk_valid(pk_valid),
    .pk_sol  (pk_sol),
    .pk_eol  (pk_eol),
    .pk_word (pk_word)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> !o_valid && !pk_valid); // R9
endmodule

// File: tb/sim_yc_alt_convert.sv
module sim_yc_alt_convert;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        in_valid = 0, in_sol = 0, in_eol = 0;
  logic [23:0] in_word = '0;
  logic        o_valid, o_sol, o_eol;
  logic [9:0]  o_y, o_cb, o_cr;
  logic        p_valid = 0, p_sol = 0, p_eol = 0;
  logic [9:0]  p_y = '0, p_cb = '0, p_cr = '0;
  logic        pk_valid, pk_sol, pk_eol;
  logic [23:0] pk_word;

  yc_alt_convert u0 (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_sol(in_sol), .in_eol(in_eol), .in_word(in_word),
    .o_valid(o_valid), .o_sol(o_sol), .o_eol(o_eol), .o_y(o_y), .o_cb(o_cb), .o_cr(o_cr),
    .p_valid(p_valid), .p_sol(p_sol), .p_eol(p_eol), .p_y(p_y), .p_cb(p_cb), .p_cr(p_cr),
    .pk_valid(pk_valid), .pk_sol(pk_sol), .pk_eol(pk_eol), .pk_word(pk_word)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // gap[49:46] sol[45] eol[44] pad[43:40] chroma[39:30] y[29:20] exp_cb[19:10] exp_cr[9:0]
  localparam int NV = 10;
  localparam logic [49:0] VEC [NV] = '{
    {4'd0, 1'b1, 1'b0, 4'h0, 10'h100, 10'h001, 10'h100, 10'h200},
    {4'd0, 1'b0, 1'b0, 4'hF, 10'h200, 10'h002, 10'h100, 10'h200},
    {4'd2, 1'b0, 1'b0, 4'h0, 10'h101, 10'h003, 10'h101, 10'h201},
    {4'd0, 1'b0, 1'b1, 4'h0, 10'h201, 10'h004, 10'h101, 10'h201},
    {4'd0, 1'b1, 1'b0, 4'h5, 10'h110, 10'h011, 10'h110, 10'h210},
    {4'd1, 1'b0, 1'b0, 4'h0, 10'h210, 10'h012, 10'h110, 10'h210},
    {4'd0, 1'b0, 1'b1, 4'hA, 10'h111, 10'h013, 10'h111, 10'h111},
    {4'd0, 1'b1, 1'b1, 4'h0, 10'h120, 10'h021, 10'h120, 10'h120},
    {4'd3, 1'b1, 1'b0, 4'h0, 10'h130, 10'h031, 10'h130, 10'h230},
    {4'd0, 1'b0, 1'b1, 4'h0, 10'h230, 10'h032, 10'h130, 10'h230}
  };

  bit mon_en = 0;
  int out_n = 0;

  // Output monitor for the vector walk: compares the n-th output with the n-th vector
  always @(negedge clk) begin
    if (mon_en && o_valid) begin
      if (out_n < NV) begin
        check(o_y == VEC[out_n][29:20], "R6 luma", {22'd0, o_y}, {22'd0, VEC[out_n][29:20]});
        check(o_cb == VEC[out_n][19:10], VEC[out_n][44] ? "R4/R3 cb" : "R3 cb",
              {22'd0, o_cb}, {22'd0, VEC[out_n][19:10]});
        check(o_cr == VEC[out_n][9:0], VEC[out_n][44] ? "R4 cr" : "R3 cr",
              {22'd0, o_cr}, {22'd0, VEC[out_n][9:0]});
        check({o_sol, o_eol} == VEC[out_n][45:44], "R5 flags",
              {30'd0, o_sol, o_eol}, {30'd0, VEC[out_n][45:44]});
      end else begin
        check(1'b0, "R5 extra output", out_n, NV);
      end
      out_n++;
    end
  end

  task automatic pk_step(input bit v, input bit s, input bit e, input logic [9:0] y,
                         input logic [9:0] cb, input logic [9:0] cr,
                         input logic [9:0] exp_c, input string req);
    p_valid = v; p_sol = s; p_eol = e; p_y = y; p_cb = cb; p_cr = cr;
    @(negedge clk);
    p_valid = 0; p_sol = 0; p_eol = 0;
    check(pk_valid == v, "R10/R7 pk_valid", {31'd0, pk_valid}, {31'd0, v});
    if (v) begin
      check(pk_word == {4'h0, exp_c, y}, req, pk_word, {8'd0, 4'h0, exp_c, y});
      check({pk_sol, pk_eol} == {s, e}, "R7 flags", {30'd0, pk_sol, pk_eol}, {30'd0, s, e});
    end
  endtask

  initial begin
    #(20 * 200000);
    check(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!o_valid && !pk_valid, "R9 in reset", {30'd0, o_valid, pk_valid}, 0);
    rst = 0;
    @(negedge clk);
    check(!o_valid && !pk_valid, "R9 after reset", {30'd0, o_valid, pk_valid}, 0);

    // Vector walk over the unpack path (R1..R6, R10)
    mon_en = 1;
    for (int i = 0; i < NV; i++) begin
      for (int g = 0; g < int'(VEC[i][49:46]); g++) begin
        in_valid = 0;
        @(negedge clk);
      end
      in_valid = 1;
      in_sol   = VEC[i][45];
      in_eol   = VEC[i][44];
      in_word  = {VEC[i][43:40], VEC[i][39:30], VEC[i][29:20]};
      @(negedge clk);
    end
    in_valid = 0; in_sol = 0; in_eol = 0;
    repeat (4) @(negedge clk);
    mon_en = 0;
    check(out_n == NV, "R5 output count", out_n, NV);

    // Directed latency on a continuous two-pixel line (R5, R2)
    in_valid = 1; in_sol = 1; in_eol = 0; in_word = {4'h0, 10'h140, 10'h03A};
    @(negedge clk);
    check(!o_valid, "R5 first pixel held", {31'd0, o_valid}, 0);
    in_sol = 0; in_eol = 1; in_word = {4'h0, 10'h240, 10'h03B};
    @(negedge clk);
    in_valid = 0; in_eol = 0;
    check(o_valid && o_sol && o_y == 10'h03A, "R5 first out", {o_valid, o_sol, o_y}, {2'b11, 10'h03A});
    check(o_cb == 10'h140 && o_cr == 10'h240, "R2 pair", {o_cb, o_cr}, {10'h140, 10'h240});
    @(negedge clk);
    check(o_valid && o_eol && o_y == 10'h03B, "R5 flush out", {o_valid, o_eol, o_y}, {2'b11, 10'h03B});
    @(negedge clk);
    check(!o_valid, "R5 idle after flush", {31'd0, o_valid}, 0);

    // Pack path (R7, R8, R10)
    pk_step(1, 1, 0, 10'h055, 10'h1AA, 10'h2BB, 10'h1AA, "R8 sol emits cb");
    pk_step(1, 0, 0, 10'h056, 10'h1AC, 10'h2BC, 10'h2BC, "R8 odd emits cr");
    pk_step(0, 0, 0, 10'h3FF, 10'h3FF, 10'h3FF, 10'h000, "R10 idle");
    pk_step(1, 0, 0, 10'h057, 10'h1AD, 10'h2BD, 10'h1AD, "R10 gap keeps phase");
    pk_step(1, 1, 1, 10'h058, 10'h1AE, 10'h2BE, 10'h1AE, "R8 restart at sol");
    pk_step(1, 1, 0, 10'h059, 10'h1AF, 10'h2BF, 10'h1AF, "R8 cb after short line");
    pk_step(1, 0, 1, 10'h05A, 10'h1B0, 10'h2C0, 10'h2C0, "R7 word layout");

    report();
  end
endmodule